// File: doc/BRIEF.md
# Branch Trace Ring Buffer

This block keeps a short history of control-flow changes. Each taken branch, interrupt or exception comes in as a one-cycle event strobe with a 32-bit source address and a 32-bit destination address. The block packs the two addresses into one 64-bit record and writes it into an eight-slot ring. A 3-bit head pointer always names the slot that holds the newest record, so software can walk backwards from the head to rebuild the recent path of execution.

A small indexed register port gives software access. Addresses 0 to 7 read the eight records. Address 8 is the head pointer. Address 9 is a control register whose bit 0 turns capture on. A debug-exception strobe clears the capture bit, which freezes the ring for inspection. Reads are combinational and have no side effects.

Top module: `branch_trace_ring`

## Requirements
- R1: Register address k, for k in 0..7, reads record k. Address 8 reads the head pointer in bits 2:0. Address 9 reads the capture-enable bit in bit 0. Every other address, and every unused bit, reads zero.
- R2: A record holds the event source address in bits 31:0 and the destination address in bits 63:32.
- R3: When an event arrives while capture is enabled, the head pointer becomes (head+1) mod 8 on that clock edge, and the record is written into the slot the new head names.
- R4: After more than eight captured events, the ring holds exactly the last eight, and each new event overwrites the oldest slot.
- R5: After reset the head pointer is 0, all eight records are 0 and capture is disabled.
- R6: An event that arrives while capture is disabled changes neither the head pointer nor any record.
- R7: A debug-exception strobe clears the capture bit at the next edge. An event in the same cycle as the strobe is still captured.
- R8: A write to address 8 loads bits 2:0 of the write data into the head pointer. The other bits of the write data are dropped.
- R9: Writes to record addresses 0..7 are ignored, and reads never change any record.
- R10: If a captured event and a head-pointer write fall in the same cycle, the event wins: the head pointer advances by one and the write data is dropped.
- R11: A write to address 9 sets the capture bit from bit 0 of the write data. A debug strobe in the same cycle wins, and the bit ends up 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 1 | One-cycle strobe for a taken branch, interrupt or exception |
| evt_src_i | input | 32 | Source address of the event |
| evt_dst_i | input | 32 | Destination address of the event |
| dbg_i | input | 1 | Debug-exception strobe; clears the capture bit |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register index |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Combinational read data for reg_addr_i |

## Verification
The bench fills the ring past one full turn and compares every slot against a model of the last eight events. A design that writes before it advances, or that treats the head as the next free slot, shows every record shifted by one slot. It drives an event and a debug strobe in the same cycle, which catches a design that drops the final event or keeps capturing after the strobe. It also drives an event together with a head-pointer write, where the wrong priority leaves the head at the written value. Writes to record addresses and a pointer write with the upper bits set show up as corrupted records or as nonzero upper read bits.

// File: rtl/brr_pkg.sv
package brr_pkg;
  localparam int ADDR_W = 32;
  localparam int REC_W  = 2 * ADDR_W;

  // dst occupies the upper half, src the lower half
  typedef struct packed {
    logic [ADDR_W-1:0] dst;
    logic [ADDR_W-1:0] src;
  } rec_t;
endpackage

// File: rtl/brr_ctrl.sv
module brr_ctrl #(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_i,
  input  logic             dbg_i,
  input  logic             ptr_we_i,
  input  logic [PTR_W-1:0] ptr_wdata_i,
  input  logic             en_we_i,
  input  logic             en_wdata_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic             en_o,
  output logic             rec_go_o,
  output logic [PTR_W-1:0] wr_idx_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] ptr_q;
  logic             en_q;

  assign rec_go_o = evt_i && en_q;
  assign wr_idx_o = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      en_q  <= 1'b0;
    end else begin
      if (rec_go_o)      ptr_q <= wr_idx_o;
      else if (ptr_we_i) ptr_q <= ptr_wdata_i;
      if (dbg_i)         en_q  <= 1'b0;
      else if (en_we_i)  en_q  <= en_wdata_i;
    end
  end

  assign ptr_o = ptr_q;
  assign en_o  = en_q;

  // R3
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_go_o |=> (($past(ptr_o) == LAST) ? (ptr_o == '0) : (ptr_o == PTR_W'($past(ptr_o) + 1'b1))));
  // R6
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rec_go_o && !ptr_we_i) |=> $stable(ptr_o));
  // R7
  dbg_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_i |=> !en_o);
endmodule

// File: rtl/brr_store.sv
module brr_store
  import brr_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [PTR_W-1:0]            idx_i,
  input  rec_t                        data_i,
  output logic [DEPTH-1:0][REC_W-1:0] recs_o
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [REC_W-1:0] slot_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        slot_q <= '0;
      else if (we_i && idx_i == PTR_W'(g)) slot_q <= data_i;
    end
    assign recs_o[g] = slot_q;
  end

  // R9
  store_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(recs_o));
endmodule

// File: rtl/brr_rdmux.sv
module brr_rdmux
  import brr_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int RA_W  = $clog2(DEPTH + 2)
) (
  input  logic [RA_W-1:0]             addr_i,
  input  logic [DEPTH-1:0][REC_W-1:0] recs_i,
  input  logic [PTR_W-1:0]            ptr_i,
  input  logic                        en_i,
  output logic [REC_W-1:0]            rdata_o
);
  localparam logic [RA_W-1:0] PTR_ADDR = RA_W'(DEPTH);
  localparam logic [RA_W-1:0] EN_ADDR  = RA_W'(DEPTH + 1);

  always_comb begin
    rdata_o = '0;
    if (addr_i < PTR_ADDR)       rdata_o = recs_i[addr_i[PTR_W-1:0]];
    else if (addr_i == PTR_ADDR) rdata_o[PTR_W-1:0] = ptr_i;
    else if (addr_i == EN_ADDR)  rdata_o[0] = en_i;
  end
endmodule

// File: rtl/branch_trace_ring.sv
module branch_trace_ring
  import brr_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int RA_W  = $clog2(DEPTH + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_i,
  input  logic [ADDR_W-1:0] evt_src_i,
  input  logic [ADDR_W-1:0] evt_dst_i,
  input  logic              dbg_i,
  input  logic              reg_we_i,
  input  logic [RA_W-1:0]   reg_addr_i,
  input  logic [REC_W-1:0]  reg_wdata_i,
  output logic [REC_W-1:0]  reg_rdata_o
);
  localparam logic [RA_W-1:0] PTR_ADDR = RA_W'(DEPTH);
  localparam logic [RA_W-1:0] EN_ADDR  = RA_W'(DEPTH + 1);

  logic [PTR_W-1:0]            ptr, wr_idx;
  logic                        en, rec_go;
  logic [DEPTH-1:0][REC_W-1:0] recs;
  rec_t                        new_rec;

  assign new_rec = '{dst: evt_dst_i, src: evt_src_i};

  brr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i, .rst_ni, .evt_i, .dbg_i,
    .ptr_we_i   (reg_we_i && reg_addr_i == PTR_ADDR),
    .ptr_wdata_i(reg_wdata_i[PTR_W-1:0]),
    .en_we_i    (reg_we_i && reg_addr_i == EN_ADDR),
    .en_wdata_i (reg_wdata_i[0]),
    .ptr_o      (ptr),
    .en_o       (en),
    .rec_go_o   (rec_go),
    .wr_idx_o   (wr_idx)
  );

  brr_store #(.DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni,
    .we_i  (rec_go),
    .idx_i (wr_idx),
    .data_i(new_rec),
    .recs_o(recs)
  );

  brr_rdmux #(.DEPTH(DEPTH)) u_rdmux (
    .addr_i (reg_addr_i),
    .recs_i (recs),
    .ptr_i  (ptr),
    .en_i   (en),
    .rdata_o(reg_rdata_o)
  );

  // R2
  newest_rec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_go |=> recs[ptr] == {$past(evt_dst_i), $past(evt_src_i)});
endmodule

// File: tb/branch_trace_ring_bench.sv
module branch_trace_ring_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        evt_i = 1'b0;
  logic [31:0] evt_src_i = '0, evt_dst_i = '0;
  logic        dbg_i = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [3:0]  reg_addr_i = '0;
  logic [63:0] reg_wdata_i = '0;
  logic [63:0] reg_rdata_o;

  int checks = 0, errors = 0;
  logic [63:0] m_rec [8];
  int          m_ptr = 0;
  bit          m_en = 0;

  always #10 clk_i = ~clk_i;

  branch_trace_ring u_branch_trace_ring (.*);

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [63:0] d);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  // one clock of stimulus, model updated by the requirement rules
  task automatic step(bit ev, logic [31:0] s, logic [31:0] d, bit dbg,
                      bit we, logic [3:0] a, logic [63:0] wd);
    bit go;
    @(negedge clk_i);
    evt_i = ev; evt_src_i = s; evt_dst_i = d; dbg_i = dbg;
    reg_we_i = we; reg_addr_i = a; reg_wdata_i = wd;
    go = ev && m_en;
    if (go) begin m_ptr = (m_ptr + 1) % 8; m_rec[m_ptr] = {d, s}; end
    else if (we && a == 4'd8) m_ptr = int'(wd[2:0]);
    if (dbg) m_en = 0;
    else if (we && a == 4'd9) m_en = wd[0];
    @(posedge clk_i);
    #1;
    evt_i = 0; dbg_i = 0; reg_we_i = 0;
  endtask

  task automatic check_all(string req);
    logic [63:0] d;
    for (int i = 0; i < 8; i++) begin
      rd(4'(i), d);
      chk(req, d, m_rec[i]);
    end
    rd(4'd8, d); chk({req, " head"}, d, 64'(m_ptr));
    rd(4'd9, d); chk({req, " enable"}, d, 64'(m_en));
  endtask

  task automatic t_reset;
    logic [63:0] d;
    check_all("R5");
    rd(4'd10, d); chk("R1 unused addr", d, '0);
    rd(4'd15, d); chk("R1 unused addr", d, '0);
  endtask

  task automatic t_disabled;
    step(1, 32'h1111_0000, 32'h2222_0000, 0, 0, 0, 0);
    check_all("R6");
  endtask

  task automatic t_enable;
    logic [63:0] d;
    step(0, 0, 0, 0, 1, 4'd9, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(4'd9, d); chk("R11 enable set", d, 64'd1);
  endtask

  task automatic t_fill;
    logic [63:0] d;
    for (int i = 0; i < 11; i++) begin
      step(1, 32'h8000_0000 + 32'(i * 16), 32'h0040_0000 ^ 32'(i * 7 + 3), 0, 0, 0, 0);
      rd(4'd8, d); chk("R3 head advance", d, 64'(m_ptr));
      rd(4'(m_ptr), d); chk("R2 packing", d, m_rec[m_ptr]);
    end
    check_all("R4 wrap");
  endtask

  task automatic t_readonly;
    step(0, 0, 0, 0, 1, 4'd2, 64'hDEAD_BEEF_CAFE_F00D);
    step(0, 0, 0, 0, 1, 4'd7, 64'h0);
    check_all("R9");
    check_all("R9 reread");
  endtask

  task automatic t_ptr_write;
    logic [63:0] d;
    step(0, 0, 0, 0, 1, 4'd8, 64'hFFFF_FFFF_FFFF_FFF5);
    rd(4'd8, d); chk("R8 head write", d, 64'd5);
    step(1, 32'hAAAA_5555, 32'h1234_5678, 0, 0, 0, 0);
    rd(4'd8, d); chk("R3 after write", d, 64'd6);
    rd(4'd6, d); chk("R3 slot", d, 64'h1234_5678_AAAA_5555);
  endtask

  task automatic t_collide;
    logic [63:0] d;
    step(1, 32'h0BAD_0001, 32'h0600_D001, 0, 1, 4'd8, 64'd2);
    rd(4'd8, d); chk("R10 event wins", d, 64'd7);
    check_all("R10");
  endtask

  task automatic t_debug;
    logic [63:0] d;
    step(1, 32'hFEED_0000, 32'hBEEF_0000, 1, 0, 0, 0);
    rd(4'd0, d); chk("R7 last event kept", d, 64'hBEEF_0000_FEED_0000);
    rd(4'd9, d); chk("R7 enable cleared", d, 64'd0);
    step(1, 32'h1, 32'h2, 0, 0, 0, 0);
    check_all("R6 frozen");
    step(0, 0, 0, 1, 1, 4'd9, 64'd1);
    rd(4'd9, d); chk("R11 debug wins", d, 64'd0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) m_rec[i] = '0;
    #45 rst_ni = 1'b1;
    t_reset();
    t_disabled();
    t_enable();
    t_fill();
    t_readonly();
    t_ptr_write();
    t_collide();
    t_debug();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #4000000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule